// File: doc/BRIEF.md
# L1 Access Steering Unit

This block sits between the instruction fetch and load/store paths of a processor core and its first-level memories. Every cycle each side may present one access: an address and a cacheable flag. The unit decides where that access is served: one of three tightly coupled memory (TCM) ports, the side's own L1 cache, a peripheral port, or the AXI master port towards L2. The TCM ports are shared by both sides. The caches follow Harvard rules: each side has a cache of its own.

Four regions are programmable: TCM A, TCM B0, TCM B1 and a peripheral window. Each region has a base, a power-of-two size and an enable. Accesses are checked in a fixed order. An enabled TCM region comes first, then the peripheral window, then the cache for cacheable accesses, and the AXI port takes whatever is left. When both sides hit the same TCM in one cycle, the data side is served and the instruction side is held back for that cycle. Error flags raised by external logic on a TCM port are returned to the side whose access is using that port.

Top module: `l1_access_router`

## Requirements
- R1: An access that hits an enabled TCM region goes to that TCM whatever its cacheable flag. When regions overlap, TCM A wins over B0 and B0 wins over B1.
- R2: Configuration has three TCM regions: sel 0 is TCM A, sel 1 is B0 and sel 2 is B1. sel 3 is the peripheral window. Each region has its own enable, and a disabled region never hits. A write takes effect for requests from the next cycle on.
- R3: Either side can reach each of the three TCM ports.
- R4: A region with size code k covers 2^k bytes. An address hits when its bits [AW-1:k] equal the same bits of the base. The low k bits of the base are ignored.
- R5: An access that misses every enabled TCM and lies in an enabled peripheral window goes to the peripheral port and never to a cache.
- R6: A cacheable access that misses the TCMs and the peripheral window goes to its own side's cache. An instruction access never reaches the data cache, and a data access never reaches the instruction cache.
- R7: Every other access goes to the AXI port. This includes cacheable accesses on a side whose cache enable is low.
- R8: When both sides target the same TCM in one cycle, the data access is routed. The instruction destination is then zero and i_stall is 1 for that one cycle. The two sides never hold the same TCM port in the same cycle.
- R9: Each destination is registered one cycle after its request. It is one-hot when the request was accepted and all-zero when there was no request. Bit 0 is TCM A, bit 1 is TCM B0, bit 2 is TCM B1, bit 3 is the peripheral port, bit 4 is the cache and bit 5 is AXI.
- R10: i_err and d_err are high exactly when tcm_err[n] is high for a TCM port n selected by that side's current destination.
- R11: After reset both destinations are zero, i_stall is low and every region is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_sel | input | 2 | Region index: 0 TCM A, 1 TCM B0, 2 TCM B1, 3 peripheral |
| cfg_base | input | AW | Region base address |
| cfg_size | input | SW | Region size code k (2^k bytes) |
| cfg_en | input | 1 | Region enable |
| icache_en | input | 1 | Instruction cache present and enabled |
| dcache_en | input | 1 | Data cache present and enabled |
| i_valid | input | 1 | Instruction access request |
| i_addr | input | AW | Instruction access address |
| i_cacheable | input | 1 | Instruction access cacheable flag |
| d_valid | input | 1 | Data access request |
| d_addr | input | AW | Data access address |
| d_cacheable | input | 1 | Data access cacheable flag |
| tcm_err | input | 3 | External error flag per TCM port (A, B0, B1) |
| i_dest | output | 6 | Registered one-hot instruction destination |
| d_dest | output | 6 | Registered one-hot data destination |
| i_stall | output | 1 | Instruction access lost TCM arbitration last cycle |
| i_err | output | 1 | TCM error for the instruction access |
| d_err | output | 1 | TCM error for the data access |

## Verification
A corrupted region register shows up as an address range steered to the wrong port. It appears on the first access into that range, one cycle after the request. Because of that, the bench sweeps every address of a 12-bit configuration on both sides. It does so with both cacheable values and with two different data-address offsets, one of which forces TCM collisions, and it repeats the sweep with a region disabled and one cache off. A bad arbitration or error-return path appears in the same cycle as the destination it belongs to. Directed steps pair each TCM port with each error flag to cover it.

// File: rtl/l1_access_router.sv
module l1_access_router #(
  parameter int AW = 32,
  localparam int SW = $clog2(AW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_base,
  input  logic [SW-1:0] cfg_size,
  input  logic          cfg_en,
  input  logic          icache_en,
  input  logic          dcache_en,
  input  logic          i_valid,
  input  logic [AW-1:0] i_addr,
  input  logic          i_cacheable,
  input  logic          d_valid,
  input  logic [AW-1:0] d_addr,
  input  logic          d_cacheable,
  input  logic [2:0]    tcm_err,
  output logic [5:0]    i_dest,
  output logic [5:0]    d_dest,
  output logic          i_stall,
  output logic          i_err,
  output logic          d_err
);
  localparam int NREG = 4;
  localparam int ND   = 6;

  logic [AW-1:0]   base_q [NREG];
  logic [SW-1:0]   size_q [NREG];
  logic [NREG-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int r = 0; r < NREG; r++) begin
        base_q[r] <= '0;
        size_q[r] <= '0;
      end
    end else if (cfg_we) begin
      base_q[cfg_sel] <= cfg_base;
      size_q[cfg_sel] <= cfg_size;
      en_q[cfg_sel]   <= cfg_en;
    end
  end

  function automatic logic in_region(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                     input logic [SW-1:0] k);
    logic [AW-1:0] m;
    for (int i = 0; i < AW; i++) m[i] = (i >= int'(k));
    return ((a ^ b) & m) == '0;
  endfunction

  function automatic logic [ND-1:0] route(input logic [NREG-1:0] h, input logic c,
                                          input logic cen);
    if (h[0])          return 6'b000001;
    else if (h[1])     return 6'b000010;
    else if (h[2])     return 6'b000100;
    else if (h[3])     return 6'b001000;
    else if (c && cen) return 6'b010000;
    else               return 6'b100000;
  endfunction

  logic [NREG-1:0] i_hit, d_hit;
  for (genvar r = 0; r < NREG; r++) begin : g_hit
    assign i_hit[r] = en_q[r] & in_region(i_addr, base_q[r], size_q[r]);
    assign d_hit[r] = en_q[r] & in_region(d_addr, base_q[r], size_q[r]);
  end

  logic [ND-1:0] i_sel, d_sel;
  logic          clash;
  assign i_sel = route(i_hit, i_cacheable, icache_en);
  assign d_sel = route(d_hit, d_cacheable, dcache_en);
  assign clash = i_valid & d_valid & (|(i_sel[2:0] & d_sel[2:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      i_dest  <= '0;
      d_dest  <= '0;
      i_stall <= 1'b0;
    end else begin
      i_dest  <= (i_valid && !clash) ? i_sel : '0;
      d_dest  <= d_valid ? d_sel : '0;
      i_stall <= clash;
    end
  end

  assign i_err = |(i_dest[2:0] & tcm_err);
  assign d_err = |(d_dest[2:0] & tcm_err);

  logic hist_ok;
  always_ff @(posedge clk) hist_ok <= rst_n;

  AST_TCM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
    (i_dest[2:0] & d_dest[2:0]) == 3'b000);                                   // R8
  AST_STALL_DATA_WINS: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
    i_stall |-> (i_dest == '0) && (d_dest[2:0] != 3'b000));                   // R8
  AST_I_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
    ($past(i_valid) && !i_stall) |-> $onehot(i_dest));                        // R9
  AST_D_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
    $past(d_valid) |-> $onehot(d_dest));                                      // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
    !$past(d_valid) |-> d_dest == '0);                                        // R9
  AST_ERR_NEEDS_TCM: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
    (i_err |-> i_dest[2:0] != 3'b000) and (d_err |-> d_dest[2:0] != 3'b000)); // R10
  AST_NO_CACHE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n || !hist_ok)
    !$past(dcache_en) |-> !d_dest[4]);                                        // R7
endmodule

// File: tb/tb_l1_access_router.sv
module tb_l1_access_router;
  localparam int AW = 12;
  localparam int SW = $clog2(AW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_en = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_size = '0;
  logic icache_en = 1'b1, dcache_en = 1'b1;
  logic i_valid = 1'b0, i_cacheable = 1'b0, d_valid = 1'b0, d_cacheable = 1'b0;
  logic [AW-1:0] i_addr = '0, d_addr = '0;
  logic [2:0] tcm_err = '0;
  logic [5:0] i_dest, d_dest;
  logic i_stall, i_err, d_err;

  l1_access_router #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_en(cfg_en), .icache_en(icache_en), .dcache_en(dcache_en),
    .i_valid(i_valid), .i_addr(i_addr), .i_cacheable(i_cacheable), .d_valid(d_valid),
    .d_addr(d_addr), .d_cacheable(d_cacheable), .tcm_err(tcm_err), .i_dest(i_dest),
    .d_dest(d_dest), .i_stall(i_stall), .i_err(i_err), .d_err(d_err));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int m_base [4];
  int m_size [4];
  bit m_en   [4];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input int base, input int k, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_base = AW'(base); cfg_size = SW'(k); cfg_en = en;
    m_base[sel] = base; m_size[sel] = k; m_en[sel] = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int model(input int a, input bit c, input bit cen);
    for (int r = 0; r < 4; r++)
      if (m_en[r] && ((a >> m_size[r]) == (m_base[r] >> m_size[r])))
        return 1 << r;
    return (c && cen) ? 16 : 32;
  endfunction

  task automatic step(input bit iv, input int ia, input bit ic, input bit dv, input int da,
                      input bit dc, input string req);
    int ei, ed;
    bit st;
    @(negedge clk);
    i_valid = iv; i_addr = AW'(ia); i_cacheable = ic;
    d_valid = dv; d_addr = AW'(da); d_cacheable = dc;
    ei = model(ia, ic, icache_en);
    ed = model(da, dc, dcache_en);
    st = iv && dv && (ei == ed) && (ei < 8);
    @(posedge clk); #1;
    chk(req, i_dest, (iv && !st) ? ei : 0);
    chk(req, d_dest, dv ? ed : 0);
    chk("R8", i_stall, st);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 4; r++) begin m_base[r] = 0; m_size[r] = 0; m_en[r] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R11", i_dest, 0); chk("R11", d_dest, 0); chk("R11", i_stall, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1, 12'h010, 1, 1, 12'h020, 1, "R11");
    cfg(0, 'h000, 8, 1);
    cfg(1, 'h4A5, 9, 1);
    cfg(2, 'h800, 7, 1);
    cfg(3, 'hC00, 10, 1);
    step(1, 12'h050, 1, 1, 12'h060, 0, "R1");
    step(1, 12'h5F0, 0, 1, 12'h880, 1, "R3");
    step(1, 12'h880, 1, 1, 12'h5F0, 0, "R3");
    step(1, 12'h4FF, 1, 1, 12'h3FF, 1, "R4");
    step(1, 12'hD00, 1, 1, 12'hFFF, 1, "R5");
    step(1, 12'h900, 1, 1, 12'h900, 0, "R6");
    step(1, 12'h900, 0, 1, 12'h900, 1, "R7");
    step(1, 12'h820, 1, 1, 12'h830, 0, "R8");
    step(1, 12'h820, 1, 0, 12'h830, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R9");
    cfg(2, 'h000, 9, 1);
    step(1, 12'h0F0, 0, 1, 12'h1F0, 1, "R1");
    cfg(2, 'h800, 7, 1);
    for (int a = 0; a < 4096; a++)
      for (int c = 0; c < 2; c++)
        step(1, a, c[0], 1, c[0] ? a ^ 'h010 : a ^ 'h404, ~c[0], "R9");
    cfg(2, 'h800, 7, 0);
    @(negedge clk); dcache_en = 1'b0;
    for (int a = 0; a < 4096; a += 3)
      step(1, a, 1, a[0], a ^ 'h001, 1, "R2");
    @(negedge clk); dcache_en = 1'b1; icache_en = 1'b0;
    step(1, 12'h900, 1, 1, 12'h900, 1, "R7");
    @(negedge clk); icache_en = 1'b1;
    cfg(2, 'h800, 7, 1);
    for (int p = 0; p < 3; p++)
      for (int e = 0; e < 8; e++) begin
        int ia, da;
        ia = (p == 0) ? 'h010 : (p == 1) ? 'h410 : 'h810;
        da = (p == 0) ? 'h410 : (p == 1) ? 'h810 : 'h010;
        step(1, ia, 0, 1, da, 0, "R10");
        tcm_err = 3'(e); #1;
        chk("R10", i_err, (e >> p) & 1);
        chk("R10", d_err, (e >> ((p + 1) % 3)) & 1);
        tcm_err = '0;
      end
    step(1, 12'h900, 1, 1, 12'hD00, 1, "R10");
    tcm_err = 3'b111; #1;
    chk("R10", i_err, 0); chk("R10", d_err, 0);
    tcm_err = '0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule